// File: doc/BRIEF.md
# Wake Event Status Logic

This block gathers wake-up requests for a power-managed system and turns them into a single active-low wake request line. It watches three kinds of source. The first is a keyboard data line and the second is a mouse data line; a low level on either counts as an event. The third is a bank of general purpose pins, where an edge in either direction counts as an event. The on-chip keyboard controller can also raise keyboard and mouse requests of its own, and per-source isolation bits can block those requests.

Every event lands in a sticky status bit. Each status bit has an enable bit beside it. Whenever a set status bit meets a set enable bit, the wake output is driven low. Software reaches the registers through a small read/write port and clears a status bit by writing a one to it. The block has two resets:
- The standby reset models the always-on rail. It clears status, enables and the output register.
- The main reset models the switched rail. It clears only the synchronisers, the pin directions and the isolation bits, so wake settings survive the main rail going down.

Top module: `wake_event_hub`

## Requirements
- R1: A low level on the synchronised keyboard line sets bit 3 of the event status register (address 0). A low level on the synchronised mouse line sets bit 4 of that register. Each external input passes through two flops before it is used.
- R2: The internal controller request for keyboard or mouse sets the matching status bit only while the matching isolation bit is 0. The isolation register is at address 5, with bit 0 for keyboard and bit 1 for mouse. A low external line still sets the flag while the source is isolated.
- R3: The standby reset clears the keyboard and mouse enable bits (address 1, bits 3 and 4) and the pin enables. The main reset leaves all enables and all status bits unchanged.
- R4: `pmeN` is low when some status bit and its enable bit are both set. It returns high on the clock edge after the edge at which the last such pair is broken, whether by a clear or by a disable.
- R5: A rising or a falling edge on a synchronised general purpose pin sets the pin's bit in the pin status register (address 2), provided the pin is an input.
- R6: A pin whose direction bit is 0 never sets its status bit. Direction bits are at address 4, where 1 means input.
- R7: Pin index `LOCKED_PIN` (default 4) never sets its status bit. Its enable bit in the pin enable register (address 3) always reads 0.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. If an event arrives in the same cycle as the clear, the bit stays set.
- R9: After both resets: all status bits are 0, all enables are 0, the direction register reads all ones, isolation reads 0 and `pmeN` is 1.
- R10: Addresses 0 to 5 select the event status, event enable, pin status, pin enable, pin direction and isolation registers, in that order. Any other address reads 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| standbyRstN | input | 1 | Asynchronous active-low reset of the always-on rail |
| mainRstN | input | 1 | Asynchronous active-low reset of the switched rail |
| kbdLine | input | 1 | External keyboard data line |
| mouseLine | input | 1 | External mouse data line |
| kbcKbdReq | input | 1 | Internal controller keyboard wake request |
| kbcMouseReq | input | 1 | Internal controller mouse wake request |
| gpioPin | input | 13 | General purpose pin levels |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for `regAddr` |
| pmeN | output | 1 | Active-low wake event request |

## Verification
The bench goes after the following corner cases:
- A clear that lands while the keyboard line is still held low. A design that gave the clear priority would drop the flag and lose a live event.
- A main-rail reset between enabling a source and reading it back. A design with the enables on the wrong rail would lose wake settings that software set before sleep.
- An output-configured pin and the locked pin index being toggled. A design that did not gate either one would raise status, and could pull the wake line low, from a pin that must stay silent.
- The exact cycle at which `pmeN` releases after a clear or a disable. A design that drove the output combinationally, or registered it one stage too many, would miss that edge.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int ADDR_W    = 3;
  localparam int KBD_BIT   = 3;
  localparam int MOUSE_BIT = 4;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_EVT_STAT = 3'd0,
    ADDR_EVT_EN   = 3'd1,
    ADDR_GP_STAT  = 3'd2,
    ADDR_GP_EN    = 3'd3,
    ADDR_GP_DIR   = 3'd4,
    ADDR_ISO      = 3'd5
  } wake_addr_e;

  typedef struct packed {
    logic wrEvtStat;
    logic wrEvtEn;
    logic wrGpStat;
    logic wrGpEn;
    logic wrGpDir;
    logic wrIso;
  } wake_strobe_t;
endpackage

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output wake_strobe_t      strobe
);
  always_comb begin
    strobe = '0;
    if (wrEn) begin
      case (addr)
        ADDR_EVT_STAT: strobe.wrEvtStat = 1'b1;
        ADDR_EVT_EN:   strobe.wrEvtEn   = 1'b1;
        ADDR_GP_STAT:  strobe.wrGpStat  = 1'b1;
        ADDR_GP_EN:    strobe.wrGpEn    = 1'b1;
        ADDR_GP_DIR:   strobe.wrGpDir   = 1'b1;
        ADDR_ISO:      strobe.wrIso     = 1'b1;
        default:       strobe = '0;
      endcase
    end
  end

  // R10: a write targets at most one register
  always_comb begin
    assert_one_strobe_R10: assert ($onehot0(strobe));
  end
endmodule

// File: rtl/wake_datapath.sv
module wake_datapath
  import wake_pkg::*;
#(
  parameter int GPIO_COUNT  = 13,
  parameter int LOCKED_PIN  = 4,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  standbyRstN,
  input  logic                  mainRstN,
  input  logic                  kbdLine,
  input  logic                  mouseLine,
  input  logic                  kbcKbdReq,
  input  logic                  kbcMouseReq,
  input  logic [GPIO_COUNT-1:0] gpioPin,
  input  wake_strobe_t          strobe,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [DATA_W-1:0]     rdData,
  output logic                  pmeN
);
  localparam int LAST = SYNC_STAGES - 1;
  localparam int PRIME_W = SYNC_STAGES + 1;
  localparam logic [GPIO_COUNT-1:0] WAKE_MASK = ~(GPIO_COUNT'(1) << LOCKED_PIN);

  // switched-rail state
  logic [SYNC_STAGES-1:0] kbdSyncQ, mouseSyncQ;
  logic [GPIO_COUNT-1:0]  gpSyncQ [SYNC_STAGES];
  logic [GPIO_COUNT-1:0]  gpPrevQ;
  logic [PRIME_W-1:0]     primeQ;
  logic [GPIO_COUNT-1:0]  gpDirQ;
  logic [1:0]             isoQ;

  // standby-rail state
  logic                  kbdStatQ, mouseStatQ, kbdEnQ, mouseEnQ, pmeNQ;
  logic [GPIO_COUNT-1:0] gpStatQ, gpEnQ;

  always_ff @(posedge clk or negedge mainRstN) begin
    if (!mainRstN) begin
      kbdSyncQ   <= '1;
      mouseSyncQ <= '1;
      for (int s = 0; s < SYNC_STAGES; s++) gpSyncQ[s] <= '0;
      gpPrevQ    <= '0;
      primeQ     <= '0;
      gpDirQ     <= '1;
      isoQ       <= '0;
    end else begin
      kbdSyncQ   <= {kbdSyncQ[SYNC_STAGES-2:0], kbdLine};
      mouseSyncQ <= {mouseSyncQ[SYNC_STAGES-2:0], mouseLine};
      gpSyncQ[0] <= gpioPin;
      for (int s = 1; s < SYNC_STAGES; s++) gpSyncQ[s] <= gpSyncQ[s-1];
      gpPrevQ    <= gpSyncQ[LAST];
      primeQ     <= {primeQ[PRIME_W-2:0], 1'b1};
      if (strobe.wrGpDir) gpDirQ <= wrData[GPIO_COUNT-1:0];
      if (strobe.wrIso)   isoQ   <= wrData[1:0];
    end
  end

  logic                  armed, kbdSet, mouseSet, anyWake;
  logic [GPIO_COUNT-1:0] gpEdge, gpClr;

  assign armed    = primeQ[PRIME_W-1];
  assign kbdSet   = ~kbdSyncQ[LAST]   | (kbcKbdReq   & ~isoQ[0]);
  assign mouseSet = ~mouseSyncQ[LAST] | (kbcMouseReq & ~isoQ[1]);
  assign gpEdge   = (gpSyncQ[LAST] ^ gpPrevQ) & gpDirQ & WAKE_MASK
                    & {GPIO_COUNT{armed}};
  assign gpClr    = strobe.wrGpStat ? wrData[GPIO_COUNT-1:0] : '0;
  assign anyWake  = (kbdStatQ & kbdEnQ) | (mouseStatQ & mouseEnQ)
                    | (|(gpStatQ & gpEnQ));

  always_ff @(posedge clk or negedge standbyRstN) begin
    if (!standbyRstN) begin
      kbdStatQ   <= 1'b0;
      mouseStatQ <= 1'b0;
      kbdEnQ     <= 1'b0;
      mouseEnQ   <= 1'b0;
      gpStatQ    <= '0;
      gpEnQ      <= '0;
      pmeNQ      <= 1'b1;
    end else begin
      kbdStatQ   <= kbdSet   | (kbdStatQ   & ~(strobe.wrEvtStat & wrData[KBD_BIT]));
      mouseStatQ <= mouseSet | (mouseStatQ & ~(strobe.wrEvtStat & wrData[MOUSE_BIT]));
      gpStatQ    <= gpEdge | (gpStatQ & ~gpClr);
      if (strobe.wrEvtEn) begin
        kbdEnQ   <= wrData[KBD_BIT];
        mouseEnQ <= wrData[MOUSE_BIT];
      end
      if (strobe.wrGpEn) gpEnQ <= wrData[GPIO_COUNT-1:0] & WAKE_MASK;
      pmeNQ <= ~anyWake;
    end
  end

  assign pmeN = pmeNQ;

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_EVT_STAT: begin
        rdData[KBD_BIT]   = kbdStatQ;
        rdData[MOUSE_BIT] = mouseStatQ;
      end
      ADDR_EVT_EN: begin
        rdData[KBD_BIT]   = kbdEnQ;
        rdData[MOUSE_BIT] = mouseEnQ;
      end
      ADDR_GP_STAT: rdData[GPIO_COUNT-1:0] = gpStatQ;
      ADDR_GP_EN:   rdData[GPIO_COUNT-1:0] = gpEnQ;
      ADDR_GP_DIR:  rdData[GPIO_COUNT-1:0] = gpDirQ;
      ADDR_ISO:     rdData[1:0] = isoQ;
      default:      rdData = '0;
    endcase
  end

  // R4: an enabled, set status bit drives the output low on the next edge
  assert_pme_low_R4: assert property (@(posedge clk) disable iff (!standbyRstN || !mainRstN)
    anyWake |=> !pmeN);
  // R4: with no enabled status pending, the output is high on the next edge
  assert_pme_high_R4: assert property (@(posedge clk) disable iff (!standbyRstN || !mainRstN)
    !anyWake |=> pmeN);
  // R2: an isolated internal request with the line idle never sets the flag
  assert_iso_blocks_R2: assert property (@(posedge clk) disable iff (!standbyRstN || !mainRstN)
    (isoQ[0] && kbdSyncQ[LAST] && !kbdStatQ) |=> !kbdStatQ);
  // R8: a write-one clear with no event pending clears the flag
  assert_w1c_R8: assert property (@(posedge clk) disable iff (!standbyRstN || !mainRstN)
    (strobe.wrEvtStat && wrData[KBD_BIT] && !kbdSet) |=> !kbdStatQ);
  // R8: a live event in the clearing cycle keeps the flag set
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!standbyRstN || !mainRstN)
    kbdSet |=> kbdStatQ);
  // R6, R7: a pin status bit only rises for a wake-capable input pin
  assert_gp_rise_R6: assert property (@(posedge clk) disable iff (!standbyRstN || !mainRstN)
    ((gpStatQ & ~$past(gpStatQ) & ~($past(gpDirQ) & WAKE_MASK)) == '0));
endmodule

// File: rtl/wake_event_hub.sv
module wake_event_hub
  import wake_pkg::*;
#(
  parameter int GPIO_COUNT  = 13,
  parameter int LOCKED_PIN  = 4,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  standbyRstN,
  input  logic                  mainRstN,
  input  logic                  kbdLine,
  input  logic                  mouseLine,
  input  logic                  kbcKbdReq,
  input  logic                  kbcMouseReq,
  input  logic [GPIO_COUNT-1:0] gpioPin,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWrEn,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  output logic                  pmeN
);
  wake_strobe_t strobe;

  wake_ctrl i_ctrl (
    .wrEn   (regWrEn),
    .addr   (regAddr),
    .strobe (strobe)
  );

  wake_datapath #(
    .GPIO_COUNT  (GPIO_COUNT),
    .LOCKED_PIN  (LOCKED_PIN),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_dp (
    .clk         (clk),
    .standbyRstN (standbyRstN),
    .mainRstN    (mainRstN),
    .kbdLine     (kbdLine),
    .mouseLine   (mouseLine),
    .kbcKbdReq   (kbcKbdReq),
    .kbcMouseReq (kbcMouseReq),
    .gpioPin     (gpioPin),
    .strobe      (strobe),
    .wrData      (regWrData),
    .rdAddr      (regAddr),
    .rdData      (regRdData),
    .pmeN        (pmeN)
  );
endmodule

// File: tb/test_wake_event_hub.sv
module test_wake_event_hub;
  logic        clk = 1'b0;
  logic        standbyRstN = 1'b0, mainRstN = 1'b0;
  logic        kbdLine = 1'b1, mouseLine = 1'b1;
  logic        kbcKbdReq = 1'b0, kbcMouseReq = 1'b0;
  logic [12:0] gpioPin = '0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        pmeN;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  wake_event_hub i_wake_event_hub (
    .clk, .standbyRstN, .mainRstN, .kbdLine, .mouseLine, .kbcKbdReq,
    .kbcMouseReq, .gpioPin, .regAddr, .regWrEn, .regWrData, .regRdData, .pmeN
  );

  always #4 clk = ~clk;

  // {kbdLine, mouseLine, kbcKbdReq, kbcMouseReq, isoKbd, isoMouse, expKbd, expMouse}
  localparam logic [7:0] VEC [8] = '{
    8'b11_00_00_00, 8'b01_00_00_10, 8'b10_00_00_01, 8'b11_10_00_10,
    8'b11_11_11_00, 8'b00_11_11_11, 8'b11_01_01_00, 8'b11_01_10_01
  };

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    cyc(3);
    standbyRstN = 1'b1; mainRstN = 1'b1;
    cyc(4);

    // R9 reset values
    rd(3'd0, d); chk("R9 status", d, 16'h0000);
    rd(3'd1, d); chk("R9 enable", d, 16'h0000);
    rd(3'd3, d); chk("R9 gp enable", d, 16'h0000);
    rd(3'd4, d); chk("R9 direction", d, 16'h1FFF);
    rd(3'd5, d); chk("R9 isolation", d, 16'h0000);
    chk("R9 pmeN", {15'd0, pmeN}, 16'h0001);
    rd(3'd7, d); chk("R10 unmapped", d, 16'h0000);

    // R1 R2 vector table
    foreach (VEC[i]) begin
      logic [7:0] v;
      v = VEC[i];
      wr(3'd5, {14'd0, v[2], v[3]});
      kbdLine = v[7]; mouseLine = v[6]; kbcKbdReq = v[5]; kbcMouseReq = v[4];
      cyc(5);
      kbdLine = 1'b1; mouseLine = 1'b1; kbcKbdReq = 1'b0; kbcMouseReq = 1'b0;
      cyc(5);
      rd(3'd0, d);
      chk($sformatf("R1/R2 vector %0d", i), d, {11'd0, v[0], v[1], 3'd0});
      wr(3'd0, 16'h0018);
      cyc(1);
    end
    wr(3'd5, 16'h0000);

    // R4 release timing after a clear
    wr(3'd1, 16'h0008);
    kbdLine = 1'b0; cyc(2); kbdLine = 1'b1; cyc(6);
    chk("R4 asserted", {15'd0, pmeN}, 16'h0000);
    wr(3'd0, 16'h0008);
    chk("R4 still low one edge after clear", {15'd0, pmeN}, 16'h0000);
    cyc(1);
    chk("R4 released", {15'd0, pmeN}, 16'h0001);

    // R8 event wins over clear, zero write keeps bit
    kbdLine = 1'b0; cyc(5);
    wr(3'd0, 16'h0008);
    rd(3'd0, d); chk("R8 set wins", d, 16'h0008);
    kbdLine = 1'b1; cyc(4);
    wr(3'd0, 16'h0000);
    rd(3'd0, d); chk("R8 zero write", d, 16'h0008);
    wr(3'd0, 16'h0008); cyc(1);
    rd(3'd0, d); chk("R8 clear", d, 16'h0000);

    // R5 either edge
    gpioPin[0] = 1'b1; cyc(5);
    rd(3'd2, d); chk("R5 rising", d, 16'h0001);
    wr(3'd2, 16'h0001); cyc(1);
    rd(3'd2, d); chk("R5 cleared", d, 16'h0000);
    gpioPin[0] = 1'b0; cyc(5);
    rd(3'd2, d); chk("R5 falling", d, 16'h0001);
    gpioPin[12] = 1'b1; cyc(5);
    rd(3'd2, d); chk("R5 top pin", d, 16'h1001);
    wr(3'd2, 16'h1FFF); cyc(1);

    // R4 disable releases output
    wr(3'd3, 16'h0001);
    gpioPin[0] = 1'b1; cyc(5);
    chk("R4 gp asserted", {15'd0, pmeN}, 16'h0000);
    wr(3'd3, 16'h0000);
    chk("R4 low until next edge", {15'd0, pmeN}, 16'h0000);
    cyc(1);
    chk("R4 released on disable", {15'd0, pmeN}, 16'h0001);
    wr(3'd2, 16'h1FFF); cyc(1);

    // R6 output pin ignored
    wr(3'd4, 16'h1FFB);
    gpioPin[2] = 1'b1; cyc(5); gpioPin[2] = 1'b0; cyc(5);
    rd(3'd2, d); chk("R6 output pin", d, 16'h0000);
    wr(3'd4, 16'h1FFF); cyc(4);
    rd(3'd2, d); chk("R6 no spurious on return", d, 16'h0000);

    // R7 locked pin
    gpioPin[4] = 1'b1; cyc(5); gpioPin[4] = 1'b0; cyc(5);
    rd(3'd2, d); chk("R7 locked status", d, 16'h0000);
    wr(3'd3, 16'h1FFF);
    rd(3'd3, d); chk("R7 locked enable", d, 16'h1FEF);
    wr(3'd3, 16'h0000);

    // R3 main reset keeps enables and status
    wr(3'd1, 16'h0018); wr(3'd3, 16'h0002);
    mouseLine = 1'b0; cyc(5); mouseLine = 1'b1; cyc(4);
    mainRstN = 1'b0; cyc(2); mainRstN = 1'b1; cyc(4);
    rd(3'd1, d); chk("R3 enable kept", d, 16'h0018);
    rd(3'd3, d); chk("R3 gp enable kept", d, 16'h0002);
    rd(3'd0, d); chk("R3 status kept", d, 16'h0010);
    chk("R3 wake still asserted", {15'd0, pmeN}, 16'h0000);
    standbyRstN = 1'b0; cyc(2); standbyRstN = 1'b1; cyc(2);
    rd(3'd1, d); chk("R3 enable cleared by standby", d, 16'h0000);
    rd(3'd3, d); chk("R3 gp enable cleared by standby", d, 16'h0000);

    // R10 unmapped write has no effect
    wr(3'd6, 16'hFFFF);
    rd(3'd4, d); chk("R10 direction untouched", d, 16'h1FFF);
    rd(3'd1, d); chk("R10 enable untouched", d, 16'h0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule